// File: doc/BRIEF.md
# Ethernet MAC Host Management Register Port

This block is the host-facing register port of an Ethernet MAC. A host presents a 10-bit address, a 2-bit opcode, a 32-bit write word, a request strobe and an MDIO select. The block sends each access either to a small bank of configuration registers or to a bank of statistics event counters. It returns 32-bit read data one cycle later.

The receiver and transmitter configuration leave the block as parallel buses that the datapaths consume directly. The receive path supplies per-event strobes, and so does the transmit path. Each strobe advances its own counter. When the MDIO select is high, the block does not decode the access. It only raises a hand-off strobe for an external serial management engine.

Top module: `mac_mgmt_regs`

## Requirements
- R1: After reset, `rdata_o`, `rx_cfg_o`, `tx_cfg_o` and every counter are zero.
- R2: With `mdio_sel_i` low, opcode 2'b01 and `addr_i[9]`=1 write `wdata_i` into one configuration register, chosen by `addr_i[8:0]`:
  - receive A at 0x000;
  - receive B at 0x040;
  - transmit at 0x080;
  - flow control at 0x0C0;
  - reconciliation at 0x100;
  - management at 0x140.
  A write to any other offset changes nothing, and a read of any other offset returns zero. For example, writing 0x300 to flow control reads back as 0x300, which leaves its upper enable bits clear.
- R3: With `mdio_sel_i` low, opcode 2'b11 and `addr_i[9]`=1, the addressed configuration register appears on `rdata_o` on the cycle after the access. `req_i` is not needed.
- R4: `rx_cfg_o` is {receive B[20:0], receive A[31:0]}, which is 53 bits. `tx_cfg_o` is transmit[9:0].
- R5: A statistics read is `req_i`=1 with opcode 2'b11, `addr_i[9]`=0 and `mdio_sel_i` low. It returns counter `addr_i[8:0]` on the next cycle. Counters 0 to 18 follow `rx_inc_i[0..18]` and counters 19 to 33 follow `tx_inc_i[0..14]`. An index of 34 or above returns zero.
- R6: A statistics-space read without `req_i`, or any cycle that is not a read, leaves `rdata_o` unchanged.
- R7: Each strobe high in a cycle adds one to its own 32-bit counter, which wraps on overflow. A counter whose strobe is low holds its value.
- R8: A counter that is read in the same cycle as it is incremented returns its value from before the increment.
- R9: Opcodes 2'b00 and 2'b10 with `mdio_sel_i` low, and every access with `mdio_sel_i` high, change no configuration register and leave `rdata_o` unchanged.
- R10: `mdio_req_o` is high exactly when `req_i` and `mdio_sel_i` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Management clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request strobe |
| opcode_i | input | 2 | 01 write, 11 read |
| addr_i | input | 10 | Bit 9 selects config space; bits 8:0 give the offset or counter index |
| wdata_i | input | 32 | Write data |
| mdio_sel_i | input | 1 | Route the access to the serial management engine |
| rx_inc_i | input | 19 | Receive event strobes |
| tx_inc_i | input | 15 | Transmit event strobes |
| rdata_o | output | 32 | Registered read data |
| rx_cfg_o | output | 53 | Receiver configuration |
| tx_cfg_o | output | 10 | Transmitter configuration |
| mdio_req_o | output | 1 | Hand-off strobe to the serial engine |

## Verification
Every configuration offset is written with a distinct data word, including an all-ones word in receive B, so that offset decoding and the 21-bit slice into `rx_cfg_o` can be told apart. Counters are driven with different event counts at the first, last and boundary indices of both banks. Reads then catch swapped or shifted index mapping, and an out-of-range index catches a missing bound check. Reads with a coincident strobe separate pre-increment from post-increment return. Reads without a request, unused opcodes and MDIO-selected accesses are each followed by an observation of `rdata_o` and the configuration buses, which shows that nothing moved.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b11;
  localparam int CFG_N     = 6;
  localparam int OFF_W     = 9;
  localparam int SLOT_LSB  = 6;  // config registers sit on 0x40 boundaries
endpackage

// File: rtl/mgmt_cfg_regs.sv
module mgmt_cfg_regs
  import mgmt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int RX_CFG_W = 53,
  parameter int TX_CFG_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [OFF_W-1:0]    off_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [RX_CFG_W-1:0] rx_cfg_o,
  output logic [TX_CFG_W-1:0] tx_cfg_o
);
  localparam int SLOT_W = OFF_W - SLOT_LSB;

  logic [DATA_W-1:0]   regs_q [CFG_N];
  logic [SLOT_W-1:0]   slot;
  logic                hit;
  logic [2*DATA_W-1:0] rx_cat;

  assign slot = off_i[OFF_W-1:SLOT_LSB];
  assign hit  = (off_i[SLOT_LSB-1:0] == '0) && (int'(slot) < CFG_N);

  for (genvar g = 0; g < CFG_N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     regs_q[g] <= '0;
      else if (wr_en_i && hit && int'(slot) == g)      regs_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < CFG_N; i++)
      if (hit && int'(slot) == i) rdata_o = regs_q[i];
  end

  assign rx_cat   = {regs_q[1], regs_q[0]};
  assign rx_cfg_o = rx_cat[RX_CFG_W-1:0];
  assign tx_cfg_o = regs_q[2][TX_CFG_W-1:0];

  AST_CFG_WR_RXA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && off_i == '0) |=> rx_cfg_o[DATA_W-1:0] == $past(wdata_i)); // R2
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(rx_cfg_o) && $stable(tx_cfg_o))); // R9
endmodule

// File: rtl/mgmt_stat_cnt.sv
module mgmt_stat_cnt
  import mgmt_pkg::*;
#(
  parameter int N     = 34,
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     inc_i,
  input  logic [OFF_W-1:0] idx_i,
  output logic [CNT_W-1:0] rdata_o
);
  logic [CNT_W-1:0] cnt_q [N];

  for (genvar g = 0; g < N; g++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_q[g] <= '0;
      else if (inc_i[g]) cnt_q[g] <= cnt_q[g] + CNT_W'(1);  // wraps
    end

    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inc_i[g] |=> cnt_q[g] == $past(cnt_q[g]) + CNT_W'(1)); // R7
    AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !inc_i[g] |=> $stable(cnt_q[g])); // R7
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N; i++)
      if (int'(idx_i) == i) rdata_o = cnt_q[i];
  end
endmodule

// File: rtl/mac_mgmt_regs.sv
module mac_mgmt_regs
  import mgmt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int RX_EV_N  = 19,
  parameter int TX_EV_N  = 15,
  parameter int RX_CFG_W = 53,
  parameter int TX_CFG_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [1:0]          opcode_i,
  input  logic [OFF_W:0]      addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                mdio_sel_i,
  input  logic [RX_EV_N-1:0]  rx_inc_i,
  input  logic [TX_EV_N-1:0]  tx_inc_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [RX_CFG_W-1:0] rx_cfg_o,
  output logic [TX_CFG_W-1:0] tx_cfg_o,
  output logic                mdio_req_o
);
  localparam int EV_N = RX_EV_N + TX_EV_N;

  logic              cfg_space, wr_cfg, rd_cfg, rd_stat;
  logic [DATA_W-1:0] cfg_rdata, stat_rdata;
  logic [DATA_W-1:0] rdata_q;

  assign cfg_space  = addr_i[OFF_W];
  assign wr_cfg     = !mdio_sel_i && opcode_i == OP_WR && cfg_space;
  assign rd_cfg     = !mdio_sel_i && opcode_i == OP_RD && cfg_space;
  assign rd_stat    = !mdio_sel_i && opcode_i == OP_RD && !cfg_space && req_i;
  assign mdio_req_o = req_i && mdio_sel_i;

  mgmt_cfg_regs #(
    .DATA_W(DATA_W), .RX_CFG_W(RX_CFG_W), .TX_CFG_W(TX_CFG_W)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_cfg),
    .off_i(addr_i[OFF_W-1:0]), .wdata_i(wdata_i), .rdata_o(cfg_rdata),
    .rx_cfg_o(rx_cfg_o), .tx_cfg_o(tx_cfg_o)
  );

  mgmt_stat_cnt #(.N(EV_N), .CNT_W(DATA_W)) u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i({tx_inc_i, rx_inc_i}),
    .idx_i(addr_i[OFF_W-1:0]), .rdata_o(stat_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_cfg)  rdata_q <= cfg_rdata;
    else if (rd_stat) rdata_q <= stat_rdata;
  end
  assign rdata_o = rdata_q;

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_cfg || rd_stat) |=> $stable(rdata_o)); // R6
  AST_MDIO_NOWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_sel_i |=> ($stable(rx_cfg_o) && $stable(tx_cfg_o) && $stable(rdata_o))); // R9
endmodule

// File: tb/mac_mgmt_regs_bench.sv
module mac_mgmt_regs_bench;
  localparam int CLK_P = 10;
  localparam int EV_N  = 34;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, sel = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [18:0] rx_inc = '0;
  logic [14:0] tx_inc = '0;
  logic [31:0] rdata;
  logic [52:0] rx_cfg;
  logic [9:0]  tx_cfg;
  logic        mdio_req;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] cnt_m [EV_N];
  logic [31:0] cfg_m [6];
  logic [31:0] last_exp = '0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_P/2) clk = ~clk;

  mac_mgmt_regs u_mac_mgmt_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .opcode_i(op), .addr_i(addr),
    .wdata_i(wdata), .mdio_sel_i(sel), .rx_inc_i(rx_inc), .tx_inc_i(tx_inc),
    .rdata_o(rdata), .rx_cfg_o(rx_cfg), .tx_cfg_o(tx_cfg), .mdio_req_o(mdio_req)
  );

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] cfg_lookup(input logic [8:0] off);
    if (off[5:0] == 0 && off[8:6] < 6) return cfg_m[off[8:6]];
    return '0;
  endfunction

  // driver: one host cycle; pushes expected rdata for the following edge
  task automatic step(input string tag, input logic rq, input logic [1:0] o,
                      input logic [9:0] a, input logic [31:0] d, input logic s,
                      input logic [18:0] ri, input logic [14:0] ti);
    logic [31:0] e;
    @(negedge clk);
    req = rq; op = o; addr = a; wdata = d; sel = s; rx_inc = ri; tx_inc = ti;
    e = last_exp;
    if (!s && o == 2'b11 && a[9]) e = cfg_lookup(a[8:0]);
    else if (!s && o == 2'b11 && !a[9] && rq) e = (a[8:0] < EV_N) ? cnt_m[a[8:0]] : 32'h0;
    if (!s && o == 2'b01 && a[9] && a[5:0] == 0 && a[8:6] < 6) cfg_m[a[8:6]] = d;
    for (int i = 0; i < 19; i++) if (ri[i]) cnt_m[i] = cnt_m[i] + 1;
    for (int i = 0; i < 15; i++) if (ti[i]) cnt_m[19+i] = cnt_m[19+i] + 1;
    last_exp = e;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    step("R6 idle", 1'b0, 2'b00, '0, '0, 1'b0, '0, '0);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) chk(tag_q.pop_front(), {32'h0, rdata}, {32'h0, exp_q.pop_front()});
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < EV_N; i++) cnt_m[i] = '0;
    for (int i = 0; i < 6; i++) cfg_m[i] = '0;
    #(CLK_P * 3);
    // R1 reset state
    chk("R1 rdata", {32'h0, rdata}, 64'h0);
    chk("R1 rx_cfg", {11'h0, rx_cfg}, 64'h0);
    chk("R1 tx_cfg", {54'h0, tx_cfg}, 64'h0);
    @(negedge clk); rst_n = 1'b1;
    idle();

    // R2 config writes, distinct words per offset
    step("R2 wr rxA", 0, 2'b01, 10'h200, 32'hDEADBEEF, 0, '0, '0);
    step("R2 wr rxB", 0, 2'b01, 10'h240, 32'hFFFFFFFF, 0, '0, '0);
    step("R2 wr tx",  0, 2'b01, 10'h280, 32'hA5A003FF, 0, '0, '0);
    step("R2 wr fc",  0, 2'b01, 10'h2C0, 32'h00000300, 0, '0, '0);
    step("R2 wr rs",  0, 2'b01, 10'h300, 32'h12345678, 0, '0, '0);
    step("R2 wr mg",  0, 2'b01, 10'h340, 32'h00000029, 0, '0, '0);
    step("R2 wr unmapped", 0, 2'b01, 10'h220, 32'hCAFEF00D, 0, '0, '0);
    idle();
    // R4 parallel buses
    chk("R4 rx_cfg", {11'h0, rx_cfg}, {11'h0, 21'h1FFFFF, 32'hDEADBEEF});
    chk("R4 tx_cfg", {54'h0, tx_cfg}, 64'h3FF);
    // R3 config reads without req
    step("R3 rd rxA", 0, 2'b11, 10'h200, '0, 0, '0, '0);
    step("R3 rd rxB", 0, 2'b11, 10'h240, '0, 0, '0, '0);
    step("R3 rd tx",  0, 2'b11, 10'h280, '0, 0, '0, '0);
    step("R2 rd fc 0x300", 0, 2'b11, 10'h2C0, '0, 0, '0, '0);
    step("R3 rd rs",  0, 2'b11, 10'h300, '0, 0, '0, '0);
    step("R3 rd mg",  0, 2'b11, 10'h340, '0, 0, '0, '0);
    step("R2 rd unmapped", 0, 2'b11, 10'h220, '0, 0, '0, '0);
    step("R2 rd rsA after gap", 0, 2'b11, 10'h300, '0, 0, '0, '0);

    // R7 events: idx0 x3, idx18 x1, idx19 x5, idx33 x2
    for (int k = 0; k < 5; k++)
      step("R7 inc", 0, 2'b00, '0, '0, 0,
           {(k == 0), 17'h0, (k < 3)}, {(k < 2), 13'h0, 1'b1});
    step("R5 rd idx0",  1, 2'b11, 10'h000, '0, 0, '0, '0);
    step("R5 rd idx18", 1, 2'b11, 10'h012, '0, 0, '0, '0);
    step("R5 rd idx19", 1, 2'b11, 10'h013, '0, 0, '0, '0);
    step("R5 rd idx33", 1, 2'b11, 10'h021, '0, 0, '0, '0);
    step("R5 rd idx34", 1, 2'b11, 10'h022, '0, 0, '0, '0);
    step("R5 rd idx1",  1, 2'b11, 10'h001, '0, 0, '0, '0);
    step("R5 rd idx0 again", 1, 2'b11, 10'h000, '0, 0, '0, '0);
    // R6 stat read without req
    step("R6 no req", 0, 2'b11, 10'h013, '0, 0, '0, '0);
    // R8 same-cycle read and increment
    step("R8 rd+inc idx0", 1, 2'b11, 10'h000, '0, 0, 19'h1, '0);
    step("R8 rd idx0 post", 1, 2'b11, 10'h000, '0, 0, '0, '0);
    step("R8 rd+inc idx33", 1, 2'b11, 10'h021, '0, 0, '0, 15'h4000);
    step("R8 rd idx33 post", 1, 2'b11, 10'h021, '0, 0, '0, '0);

    // R9 unused opcodes and MDIO-selected accesses
    step("R9 op00 wr", 1, 2'b00, 10'h200, 32'h11111111, 0, '0, '0);
    step("R9 op10",    1, 2'b10, 10'h200, 32'h22222222, 0, '0, '0);
    @(negedge clk);
    req = 1; op = 2'b01; addr = 10'h200; wdata = 32'h33333333; sel = 1;
    #1 chk("R10 mdio_req high", {63'h0, mdio_req}, 64'h1);
    exp_q.push_back(last_exp); tag_q.push_back("R9 mdio wr rdata");
    step("R9 mdio rd", 1, 2'b11, 10'h200, '0, 1, '0, '0);
    @(negedge clk);
    req = 0; op = 2'b11; addr = 10'h000; sel = 1;
    #1 chk("R10 mdio_req low w/o req", {63'h0, mdio_req}, 64'h0);
    exp_q.push_back(last_exp); tag_q.push_back("R9 mdio no req");
    @(negedge clk);
    req = 1; sel = 0;
    #1 chk("R10 mdio_req low w/o sel", {63'h0, mdio_req}, 64'h0);
    req = 0; op = 2'b00;
    exp_q.push_back(last_exp); tag_q.push_back("R9 idle");
    idle();
    chk("R9 rx_cfg kept", {11'h0, rx_cfg}, {11'h0, 21'h1FFFFF, 32'hDEADBEEF});
    step("R9 rd rxA kept", 0, 2'b11, 10'h200, '0, 0, '0, '0);
    idle();
    idle();
    finish_run();
  end
endmodule